// File: doc/BRIEF.md
# System-Management Interrupt Sequencer with Protected Memory Window

This block pairs the platform-side logic that raises a system-management interrupt with a small model of the processor's answer to it. Event inputs, each gated by an enable mask, and a periodic timeout counter set a pending request. The processor-side sequencer takes that request only at an instruction-boundary strobe and then raises an active flag. It then writes a fixed number of context words into a protected memory window. It stays in a handler phase until a resume strobe arrives, reads the same number of words back, drops the active flag and returns to idle.

A configuration register set holds the window base, the window size (a power of two, so the base is aligned down to the size) and an enable. A lock bit freezes that set until reset. All processor memory requests pass through a steering stage. While the flag is high, every request is folded into the window. While it is low, any request that hits the window is blocked and recorded in a sticky violation flag that software clears by writing one.

Top module: `smm_gate_top`

## Requirements
- R1: An event input that is high in a cycle sets a pending request at that clock edge only if its mask bit (config select 0, bit i for input i) is set. With the sequencer idle, `smi_req` goes high right after that edge. Masked inputs have no effect.
- R2: Writing a non-zero limit L to config select 1 restarts the timeout count, and the counter sets a pending request at the L-th clock edge after the write edge, then repeats every L edges. A limit of 0 stops it.
- R3: A pending request is taken only at an instruction-boundary strobe (`ibnd_stb`) while the request is outstanding. `smm_active` rises right after the edge that samples the strobe, and a strobe with no outstanding request does nothing.
- R4: The first cycle with `smm_active` high carries no memory traffic. Then XFER_WORDS consecutive cycles each issue one write to window slot i (i = 0 upward, slot address = aligned base OR i) with data `ctx_word`, while `xfer_idx` = i.
- R5: In the handler phase, with the window enabled, a processor request to address A reaches memory at (base aligned down to 2^size) OR (A mod 2^size), with the same direction and write data.
- R6: A `rsm_stb` in the handler phase starts XFER_WORDS consecutive read cycles of slots 0 upward, each with `ctx_load` high and `cpu_rdata` equal to the memory data. One cycle with `smm_active` low and no traffic follows, and then the block is idle again.
- R7: With `smm_active` low and the window enabled, a request whose address lies in the window produces no memory request, returns zero on `cpu_rdata` and sets `viol_flag` at the next edge. Requests outside the window pass through unchanged.
- R8: `viol_flag` stays set until a config write to select 4 with bit 0 = 1. A write with bit 0 = 0 leaves it set, and a new violation in the same cycle as the clear wins.
- R9: The window control word is written through config select 3 (bit 0 enable, bit 1 lock, bits [LGW+1:2] size exponent, clamped to AW) and the base through select 2. Once lock is set, writes to selects 2 and 3 are ignored until reset. Reset leaves the window disabled, so all requests pass through.
- R10: `smi_req` is low whenever `smm_active` is high. Events that fire during the mode are held, and `smi_req` goes high in the first idle cycle after the exit cycle.
- R11: During and right after reset, `smi_req`, `smm_active`, `viol_flag`, `ctx_load` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | N_EVT | Event sources, high for one cycle per event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | CFGW | Configuration write data |
| ibnd_stb | input | 1 | Instruction-boundary strobe from the processor |
| rsm_stb | input | 1 | Resume strobe from the handler |
| smi_req | output | 1 | Interrupt request to the processor |
| smm_active | output | 1 | Management mode active flag |
| ctx_word | input | DW | Context word to save for the current `xfer_idx` |
| xfer_idx | output | CW | Index of the current save or restore word |
| ctx_load | output | 1 | Restore word valid on `cpu_rdata` |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read data to the processor, zero when blocked |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the request cycle |
| viol_flag | output | 1 | Sticky window access violation |

## Verification
The hardest situation to reach from the ports is a pending request that was latched while the mode was still active. It only shows up as `smi_req` in the single idle cycle after exit. The stimulus pulses an enabled event during the handler's constrained-random accesses, walks the restore and exit cycles one at a time, and checks for the request in that idle cycle. A second full entry then drains it. The timeout path is timed from the write edge by counting edges until the request appears, and the set-wins case for the violation flag is reached by driving a blocked access in the same cycle as the clear write.

// File: rtl/smm_pkg.sv
`timescale 1ns/1ps
package smm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BND,
    ST_SAVE,
    ST_HANDLER,
    ST_RESTORE,
    ST_EXIT
  } smm_state_e;

  localparam logic [2:0] SEL_EVT_MASK = 3'd0;
  localparam logic [2:0] SEL_TMO_LIM  = 3'd1;
  localparam logic [2:0] SEL_WIN_BASE = 3'd2;
  localparam logic [2:0] SEL_WIN_CTL  = 3'd3;
  localparam logic [2:0] SEL_VIOL_CLR = 3'd4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // offset mask of a window of 2^lg words
  function automatic logic [31:0] win_mask(input logic [7:0] lg);
    logic [31:0] m;
    if (lg >= 8'd32) m = '1;
    else             m = (32'd1 << lg) - 32'd1;
    return m;
  endfunction

  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [7:0]  lg);
    return ((addr ^ base) & ~win_mask(lg)) == 32'd0;
  endfunction

  function automatic logic [31:0] fold_addr(input logic [31:0] addr,
                                            input logic [31:0] base,
                                            input logic [7:0]  lg);
    logic [31:0] m;
    m = win_mask(lg);
    return (base & ~m) | (addr & m);
  endfunction

endpackage

// File: rtl/smm_evt_unit.sv
`timescale 1ns/1ps
module smm_evt_unit import smm_pkg::*; #(
  parameter int NE = 4,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_in,
  input  logic          mask_we,
  input  logic [NE-1:0] mask_wdata,
  input  logic          lim_we,
  input  logic [TW-1:0] lim_wdata,
  input  logic          accept,
  output logic          pend,
  output logic          evt_fire,
  output logic          tmo_expire
);

  logic [NE-1:0] en_mask;
  logic [TW-1:0] lim_q;
  logic [TW-1:0] cnt_q;
  logic          src_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) en_mask <= '0;
    else if (mask_we) en_mask <= mask_wdata;
  end

  assign tmo_expire = (lim_q != '0) && (cnt_q == lim_q - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (lim_we) begin
      lim_q <= lim_wdata;
      cnt_q <= '0;
    end else if (lim_q != '0) begin
      if (tmo_expire) cnt_q <= '0;
      else            cnt_q <= cnt_q + TW'(1);
    end
  end

  assign src_hit  = |(evt_in & en_mask);
  assign evt_fire = src_hit | tmo_expire;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~accept) | evt_fire;
  end

endmodule

// File: rtl/smm_win_cfg.sv
`timescale 1ns/1ps
module smm_win_cfg import smm_pkg::*; #(
  parameter int AW  = 16,
  parameter int LGW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           base_we,
  input  logic [AW-1:0]  base_wdata,
  input  logic           ctl_we,
  input  logic [LGW+1:0] ctl_wdata,
  output logic [AW-1:0]  win_base,
  output logic [LGW-1:0] win_lg,
  output logic           win_en,
  output logic           win_lock,
  output logic           cfg_drop
);

  function automatic logic [LGW-1:0] clamp_lg(input logic [LGW-1:0] v);
    return (v > LGW'(AW)) ? LGW'(AW) : v;
  endfunction

  assign cfg_drop = win_lock && (base_we || ctl_we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_base <= '0;
      win_lg   <= '0;
      win_en   <= 1'b0;
      win_lock <= 1'b0;
    end else if (!win_lock) begin
      if (base_we) win_base <= base_wdata;
      if (ctl_we) begin
        win_en   <= ctl_wdata[0];
        win_lock <= ctl_wdata[1];
        win_lg   <= clamp_lg(ctl_wdata[LGW+1:2]);
      end
    end
  end

endmodule

// File: rtl/smm_seq.sv
`timescale 1ns/1ps
module smm_seq import smm_pkg::*; #(
  parameter int XW = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend,
  input  logic          ibnd_stb,
  input  logic          rsm_stb,
  output smm_state_e    state,
  output logic          accept,
  output logic          smi_req,
  output logic          smm_active,
  output logic          busy,
  output logic          save_beat,
  output logic          restore_beat,
  output logic [CW-1:0] xfer_idx
);

  smm_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign state        = st_q;
  assign accept       = (st_q == ST_IDLE) && pend;
  assign smi_req      = (st_q == ST_WAIT_BND) || accept;
  assign smm_active   = (st_q == ST_SAVE) || (st_q == ST_HANDLER) || (st_q == ST_RESTORE);
  assign busy         = (st_q == ST_SAVE) || (st_q == ST_RESTORE);
  // count 0 of the save phase is the announce cycle with no traffic
  assign save_beat    = (st_q == ST_SAVE) && (cnt_q != '0);
  assign restore_beat = (st_q == ST_RESTORE);
  assign xfer_idx     = save_beat ? (cnt_q - CW'(1)) : cnt_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:     if (pend) st_d = ST_WAIT_BND;
      ST_WAIT_BND: if (ibnd_stb) begin
                     st_d  = ST_SAVE;
                     cnt_d = '0;
                   end
      ST_SAVE:     if (cnt_q == CW'(XW)) begin
                     st_d  = ST_HANDLER;
                     cnt_d = '0;
                   end else begin
                     cnt_d = cnt_q + CW'(1);
                   end
      ST_HANDLER:  if (rsm_stb) begin
                     st_d  = ST_RESTORE;
                     cnt_d = '0;
                   end
      ST_RESTORE:  if (cnt_q == CW'(XW - 1)) begin
                     st_d  = ST_EXIT;
                     cnt_d = '0;
                   end else begin
                     cnt_d = cnt_q + CW'(1);
                   end
      ST_EXIT:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/smm_mem_steer.sv
`timescale 1ns/1ps
module smm_mem_steer import smm_pkg::*; #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int LGW = 5,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           save_beat,
  input  logic           restore_beat,
  input  logic           busy,
  input  logic           active,
  input  logic [CW-1:0]  xfer_idx,
  input  logic [DW-1:0]  ctx_word,
  input  logic [AW-1:0]  win_base,
  input  logic [LGW-1:0] win_lg,
  input  logic           win_en,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           viol_clr,
  output logic           win_hit,
  output logic           viol_set,
  output logic           viol_flag
);

  logic [AW-1:0] slot_addr;
  logic [AW-1:0] folded;

  assign slot_addr = AW'(fold_addr(32'(xfer_idx), 32'(win_base), 8'(win_lg)));
  assign folded    = AW'(fold_addr(32'(cpu_addr), 32'(win_base), 8'(win_lg)));
  assign win_hit   = win_en && in_window(32'(cpu_addr), 32'(win_base), 8'(win_lg));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    viol_set  = 1'b0;
    if (save_beat) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = slot_addr;
      mem_wdata = ctx_word;
    end else if (restore_beat) begin
      mem_req   = 1'b1;
      mem_addr  = slot_addr;
    end else if (busy) begin
      // processor requests are not forwarded while context moves
      mem_req   = 1'b0;
    end else if (cpu_req) begin
      if (active && win_en) begin
        mem_req   = 1'b1;
        mem_we    = cpu_we;
        mem_addr  = folded;
        mem_wdata = cpu_wdata;
      end else if (!active && win_hit) begin
        viol_set  = 1'b1;
      end else begin
        mem_req   = 1'b1;
        mem_we    = cpu_we;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
      end
    end
  end

  assign cpu_rdata = (mem_req && !mem_we) ? mem_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)        viol_flag <= 1'b0;
    else if (viol_set) viol_flag <= 1'b1;
    else if (viol_clr) viol_flag <= 1'b0;
  end

endmodule

// File: rtl/smm_gate_top.sv
`timescale 1ns/1ps
module smm_gate_top import smm_pkg::*; #(
  parameter int N_EVT      = 4,
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int XFER_WORDS = 4,
  parameter int TMO_W      = 16,
  localparam int CW        = $clog2(XFER_WORDS + 1),
  localparam int LGW       = $clog2(AW + 1),
  localparam int CFGW      = imax(imax(TMO_W, AW), imax(LGW + 2, N_EVT))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [CFGW-1:0]  cfg_wdata,
  input  logic             ibnd_stb,
  input  logic             rsm_stb,
  output logic             smi_req,
  output logic             smm_active,
  input  logic [DW-1:0]    ctx_word,
  output logic [CW-1:0]    xfer_idx,
  output logic             ctx_load,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             viol_flag
);

  // named internal events, also used by the bound checker
  smm_state_e     state;
  logic           pend, accept, evt_fire, tmo_expire;
  logic           busy, save_beat, restore_beat;
  logic           win_en, win_lock, win_hit, cfg_drop;
  logic [AW-1:0]  win_base;
  logic [LGW-1:0] win_lg;
  logic           viol_set, viol_clr;
  logic           mask_we, lim_we, base_we, ctl_we;

  assign mask_we  = cfg_we && (cfg_sel == SEL_EVT_MASK);
  assign lim_we   = cfg_we && (cfg_sel == SEL_TMO_LIM);
  assign base_we  = cfg_we && (cfg_sel == SEL_WIN_BASE);
  assign ctl_we   = cfg_we && (cfg_sel == SEL_WIN_CTL);
  assign viol_clr = cfg_we && (cfg_sel == SEL_VIOL_CLR) && cfg_wdata[0];

  smm_evt_unit #(.NE(N_EVT), .TW(TMO_W)) i_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .mask_we    (mask_we),
    .mask_wdata (cfg_wdata[N_EVT-1:0]),
    .lim_we     (lim_we),
    .lim_wdata  (cfg_wdata[TMO_W-1:0]),
    .accept     (accept),
    .pend       (pend),
    .evt_fire   (evt_fire),
    .tmo_expire (tmo_expire)
  );

  smm_win_cfg #(.AW(AW), .LGW(LGW)) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_wdata (cfg_wdata[AW-1:0]),
    .ctl_we     (ctl_we),
    .ctl_wdata  (cfg_wdata[LGW+1:0]),
    .win_base   (win_base),
    .win_lg     (win_lg),
    .win_en     (win_en),
    .win_lock   (win_lock),
    .cfg_drop   (cfg_drop)
  );

  smm_seq #(.XW(XFER_WORDS), .CW(CW)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend         (pend),
    .ibnd_stb     (ibnd_stb),
    .rsm_stb      (rsm_stb),
    .state        (state),
    .accept       (accept),
    .smi_req      (smi_req),
    .smm_active   (smm_active),
    .busy         (busy),
    .save_beat    (save_beat),
    .restore_beat (restore_beat),
    .xfer_idx     (xfer_idx)
  );

  smm_mem_steer #(.AW(AW), .DW(DW), .LGW(LGW), .CW(CW)) i_steer (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_beat    (save_beat),
    .restore_beat (restore_beat),
    .busy         (busy),
    .active       (smm_active),
    .xfer_idx     (xfer_idx),
    .ctx_word     (ctx_word),
    .win_base     (win_base),
    .win_lg       (win_lg),
    .win_en       (win_en),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .viol_clr     (viol_clr),
    .win_hit      (win_hit),
    .viol_set     (viol_set),
    .viol_flag    (viol_flag)
  );

  assign ctx_load = restore_beat;

endmodule

// File: rtl/smm_gate_chk.sv
`timescale 1ns/1ps
module smm_gate_chk import smm_pkg::*; #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int LGW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smi_req,
  input logic           smm_active,
  input logic           ibnd_stb,
  input logic           save_beat,
  input logic           restore_beat,
  input logic           viol_set,
  input logic           viol_clr,
  input logic           viol_flag,
  input logic           win_en,
  input logic           win_lock,
  input logic [AW-1:0]  win_base,
  input logic [LGW-1:0] win_lg,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  cpu_rdata
);

  assert_active_after_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smm_active) |-> $past(ibnd_stb));

  assert_save_after_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    save_beat |-> $past(smm_active));

  assert_steer_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_active && win_en && mem_req) |->
      in_window(32'(mem_addr), 32'(win_base), 8'(win_lg)));

  assert_single_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_beat, restore_beat}));

  assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_set |-> (!mem_req && cpu_rdata == '0));

  assert_viol_records_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_set |=> viol_flag);

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);

  assert_lock_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_lock |=> (win_lock && $stable(win_base) && $stable(win_en) && $stable(win_lg)));

  assert_no_req_while_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smm_active |-> !smi_req);

endmodule

bind smm_gate_top smm_gate_chk #(.AW(AW), .DW(DW), .LGW(LGW)) i_smm_gate_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smi_req      (smi_req),
  .smm_active   (smm_active),
  .ibnd_stb     (ibnd_stb),
  .save_beat    (save_beat),
  .restore_beat (restore_beat),
  .viol_set     (viol_set),
  .viol_clr     (viol_clr),
  .viol_flag    (viol_flag),
  .win_en       (win_en),
  .win_lock     (win_lock),
  .win_base     (win_base),
  .win_lg       (win_lg),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .cpu_rdata    (cpu_rdata)
);

// File: tb/test_smm_gate_top.sv
`timescale 1ns/1ps
module test_smm_gate_top;

  localparam int NE = 4, AW = 16, DW = 32, NW = 4, TW = 16;
  localparam int CW = $clog2(NW + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NE-1:0] evt_in;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [15:0]   cfg_wdata;
  logic          ibnd_stb, rsm_stb;
  logic          smi_req, smm_active, ctx_load;
  logic [DW-1:0] ctx_word;
  logic [CW-1:0] xfer_idx;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          viol_flag;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  // window programmed by the bench: base 0x4012, 64 words
  logic [AW-1:0] bb  = 16'h4012;
  int            blg = 6;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, a ^ 16'hFFFF};
  endfunction

  function automatic logic [AW-1:0] exp_fold(input logic [AW-1:0] a);
    int sz;
    sz = 1 << blg;
    return 16'((int'(bb) / sz) * sz + (int'(a) % sz));
  endfunction

  function automatic bit exp_inside(input logic [AW-1:0] a);
    return (int'(a) >> blg) == (int'(bb) >> blg);
  endfunction

  assign mem_rdata = pat(mem_addr);
  assign ctx_word  = 32'hC0DE0000 + 32'(xfer_idx);

  smm_gate_top i_smm_gate_top (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ibnd_stb(ibnd_stb), .rsm_stb(rsm_stb), .smi_req(smi_req),
    .smm_active(smm_active), .ctx_word(ctx_word), .xfer_idx(xfer_idx), .ctx_load(ctx_load),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .viol_flag(viol_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // precondition: request outstanding (waiting for boundary)
  task automatic run_mode(input int waitc, input bit fire_inside);
    for (int w = 0; w < waitc; w++) begin
      chk(!smm_active && smi_req, "R3", "waits for boundary", {smm_active, smi_req}, 32'h1);
      step();
    end
    ibnd_stb = 1'b1;
    step();
    ibnd_stb = 1'b0;
    #1;
    chk(smm_active == 1'b1, "R3", "active after boundary", smm_active, 1);
    chk(mem_req == 1'b0, "R4", "announce cycle quiet", mem_req, 0);
    chk(smi_req == 1'b0, "R10", "no request while active", smi_req, 0);
    step();
    for (int i = 0; i < NW; i++) begin
      #1;
      chk(mem_req && mem_we && mem_addr == exp_fold(16'(i)), "R4", "save slot addr",
          mem_addr, exp_fold(16'(i)));
      chk(mem_wdata == 32'hC0DE0000 + 32'(i) && xfer_idx == CW'(i), "R4", "save data",
          mem_wdata, 32'hC0DE0000 + 32'(i));
      step();
    end
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      logic          w;
      a = 16'($urandom());
      w = 1'($urandom());
      cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = $urandom();
      if (fire_inside && k == 5) evt_in = 4'b0001;
      #1;
      chk(mem_req && mem_addr == exp_fold(a) && mem_we == w, "R5", "handler fold",
          mem_addr, exp_fold(a));
      if (!w) chk(cpu_rdata == pat(exp_fold(a)), "R5", "handler read data",
                  cpu_rdata, pat(exp_fold(a)));
      step();
      evt_in = '0;
      chk(smi_req == 1'b0 && smm_active, "R10", "held while active", smi_req, 0);
    end
    cpu_req = 1'b0;
    rsm_stb = 1'b1;
    step();
    rsm_stb = 1'b0;
    for (int i = 0; i < NW; i++) begin
      #1;
      chk(mem_req && !mem_we && mem_addr == exp_fold(16'(i)) && ctx_load, "R6",
          "restore slot", mem_addr, exp_fold(16'(i)));
      chk(cpu_rdata == pat(exp_fold(16'(i))), "R6", "restore data",
          cpu_rdata, pat(exp_fold(16'(i))));
      step();
    end
    #1;
    chk(!smm_active && !mem_req && !smi_req, "R6", "exit cycle",
        {smm_active, mem_req, smi_req}, 0);
    step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int  seen;
    bit  any_hit;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; evt_in = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    ibnd_stb = 1'b0; rsm_stb = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0;
    repeat (3) step();
    chk(!smi_req && !smm_active && !viol_flag && !mem_req && !ctx_load, "R11",
        "reset outputs", {smi_req, smm_active, viol_flag, mem_req, ctx_load}, 0);
    rst_n = 1'b1;
    step();
    chk(!smi_req && !smm_active && !viol_flag, "R11", "after reset",
        {smi_req, smm_active, viol_flag}, 0);

    // R9: window disabled at reset, address 0 passes
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0000;
    #1;
    chk(mem_req && mem_addr == 16'h0000, "R9", "reset window disabled", mem_addr, 0);
    step();
    cpu_req = 1'b0;
    chk(!viol_flag, "R9", "no violation when disabled", viol_flag, 0);

    // R3: boundary strobe with nothing outstanding
    ibnd_stb = 1'b1;
    step();
    ibnd_stb = 1'b0;
    chk(!smm_active, "R3", "stray boundary ignored", smm_active, 0);

    // window: base 0x4012, exponent 6, enabled
    cfg_write(3'd2, bb);
    cfg_write(3'd3, 16'(1 | (blg << 2)));

    // R7: random accesses outside the mode
    any_hit = 1'b0;
    for (int k = 0; k < 20; k++) begin
      logic [AW-1:0] a;
      logic          w;
      a = 16'($urandom());
      if (k % 2 == 0) a = 16'h4000 | (a & 16'h003F);
      w = 1'($urandom());
      cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = $urandom();
      #1;
      if (exp_inside(a)) begin
        any_hit = 1'b1;
        chk(!mem_req && cpu_rdata == '0, "R7", "blocked in window", {mem_req, cpu_rdata}, 0);
      end else begin
        chk(mem_req && mem_addr == a && mem_we == w, "R7", "outside passes", mem_addr, a);
        if (!w) chk(cpu_rdata == pat(a), "R7", "outside read", cpu_rdata, pat(a));
      end
      step();
      chk(viol_flag == any_hit, "R7", "violation flag", viol_flag, any_hit);
    end
    cpu_req = 1'b0;

    // R8: clear semantics
    cfg_write(3'd4, 16'h0000);
    chk(viol_flag, "R8", "write zero keeps flag", viol_flag, 1);
    cfg_write(3'd4, 16'h0001);
    chk(!viol_flag, "R8", "write one clears", viol_flag, 0);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h4001;
    cfg_write(3'd4, 16'h0001);
    cpu_req = 1'b0;
    chk(viol_flag, "R8", "set wins over clear", viol_flag, 1);
    cfg_write(3'd4, 16'h0001);

    // R1: masked events ignored, enabled event raises request
    cfg_write(3'd0, 16'h0000);
    evt_in = 4'b1111;
    step();
    evt_in = '0;
    chk(!smi_req, "R1", "masked events", smi_req, 0);
    step();
    chk(!smi_req, "R1", "masked events stay quiet", smi_req, 0);
    cfg_write(3'd0, 16'h0005);
    evt_in = 4'b0010;
    step();
    evt_in = '0;
    chk(!smi_req, "R1", "bit 1 disabled", smi_req, 0);
    evt_in = 4'b0100;
    step();
    evt_in = '0;
    chk(smi_req, "R1", "enabled event request", smi_req, 1);
    step();

    // full entry with an event fired in the handler
    run_mode(3, 1'b1);
    chk(smi_req && !smm_active, "R10", "pending after exit", smi_req, 1);
    step();
    run_mode(0, 1'b0);
    chk(!smi_req, "R10", "drained", smi_req, 0);

    // R2: timeout
    cfg_write(3'd1, 16'd10);
    seen = 0;
    while (!smi_req && seen < 50) begin
      step();
      seen++;
    end
    chk(seen == 10, "R2", "timeout edges", seen, 10);
    cfg_write(3'd1, 16'd0);
    run_mode(1, 1'b0);
    for (int k = 0; k < 30; k++) step();
    chk(!smi_req, "R2", "limit zero stops", smi_req, 0);

    // R9: lock freezes the window
    cfg_write(3'd3, 16'(3 | (blg << 2)));
    cfg_write(3'd2, 16'h8000);
    cfg_write(3'd3, 16'h0000);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h4005;
    #1;
    chk(!mem_req && cpu_rdata == '0, "R9", "locked window still blocks", mem_req, 0);
    step();
    cpu_addr = 16'h8005;
    #1;
    chk(mem_req && mem_addr == 16'h8005, "R9", "ignored base write", mem_addr, 16'h8005);
    step();
    cpu_req = 1'b0;
    chk(viol_flag, "R9", "violation under lock", viol_flag, 1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule